// File: doc/BRIEF.md
# Retimed Edge Weight Checker

This block evaluates a proposed retiming of a synchronous dataflow graph. The graph is held on chip as a list of directed edges, each with a source node, a destination node and an unsigned register count. A second store holds one signed retiming offset per node. After both are loaded through their write ports, a start pulse streams the active edges through a two-stage pipeline, one edge per clock, in ascending index order. For each edge the pipeline computes the new register count and stores it.

When the pass completes, software or a neighbouring engine can read any retimed count by edge index. It can also read a legality flag that says whether every retimed count is non-negative, meaning the retimed circuit stays causal. When the flag is low, a second output gives the lowest edge index that broke the rule. An optional total check compares the sum of original counts with the sum of retimed counts. On a graph whose edges form closed loops these two sums must match, because moving registers through nodes never changes the number of registers around a loop.

Top module: `rtw_checker`

## Requirements
- R1: After a pass, `rd_weight` for edge index i (i < active count) equals w + r(dst) − r(src), as an 8-bit two's-complement value. r values are 6-bit two's complement, and w is 6-bit unsigned. A self-loop (src = dst) keeps its original count.
- R2: After a pass, `legal` is 1 exactly when every active edge has a retimed count ≥ 0.
- R3: When `legal` is 0 after a pass, `viol_idx` holds the lowest active edge index whose retimed count is negative.
- R4: With N ≥ 1 active edges and `start` sampled at clock edge E0, `done` is high for exactly one cycle, in the cycle after edge E(N+1). `busy` is high from E0 until that same edge.
- R5: With an active count of 0, `done` rises in the cycle right after the start edge, and `legal` reads 1.
- R6: A `start` pulse, or a change of `num_edges`, while `busy` is high has no effect on the pass in progress: not on its timing, its results or its legality.
- R7: Adding the same constant to every node's r leaves every retimed count unchanged.
- R8: After a pass, `total_ok` is 1 exactly when the sum of retimed counts over the active edges equals the sum of the original counts. It is always 1 for a graph made only of closed loops.
- R9: After reset, `busy` and `done` are 0, `legal` is 1, `viol_idx` is 0 and `total_ok` is 1.
- R10: Edges at indices ≥ the active count are not evaluated. A negative count on such an edge does not clear `legal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_we | input | 1 | Edge store write enable |
| edge_waddr | input | 5 | Edge index to write |
| edge_src | input | 4 | Source node of the written edge |
| edge_dst | input | 4 | Destination node of the written edge |
| edge_w | input | 6 | Original register count of the written edge |
| node_we | input | 1 | Retiming store write enable |
| node_waddr | input | 4 | Node to write |
| node_r | input | 6 | Signed retiming offset for that node |
| num_edges | input | 6 | Active edge count, 0 to 32, sampled at start |
| start | input | 1 | Begin a pass (ignored while busy) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass completion pulse |
| rd_idx | input | 5 | Edge index for result readout |
| rd_weight | output | 8 | Signed retimed count of edge `rd_idx` |
| legal | output | 1 | All retimed counts non-negative |
| viol_idx | output | 5 | Lowest violating edge index, valid when legal is 0 |
| total_ok | output | 1 | Total register count preserved |

## Verification
The bench targets the arithmetic extremes: the largest count with the most positive destination offset and most negative source offset, which gives +126, and the reverse case, which gives −63. A design that truncated or zero-extended the offsets would wrap these to wrong values of the opposite sign. It places violations at index 0, at the last active index and at several indices in one pass, so that a design reporting the latest rather than the earliest offender, or sampling a neighbour, is caught. It also sets a negative edge just past the active count to expose an off-by-one in the stop condition. It fires a second start in the middle of a pass to catch a sequencer that restarts. It shifts all offsets by a constant and compares counts, checks the cycle totals on a ring graph, and measures the exact done latency, including the empty pass.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
    localparam int EDGES  = 32;
    localparam int NODES  = 16;
    localparam int WBITS  = 6;
    localparam int RBITS  = 6;
    localparam int EIDX   = $clog2(EDGES);
    localparam int NIDX   = $clog2(NODES);
    localparam int CNTB   = $clog2(EDGES + 1);
    localparam int WRBITS = WBITS + 2;
    localparam int SUMB   = WRBITS + EIDX + 1;

    typedef struct packed {
        logic [NIDX-1:0]  src;
        logic [NIDX-1:0]  dst;
        logic [WBITS-1:0] w;
    } edge_t;

    typedef struct packed {
        logic                    vld;
        logic                    last;
        logic [EIDX-1:0]         idx;
        logic [WBITS-1:0]        w;
        logic signed [RBITS-1:0] r_src;
        logic signed [RBITS-1:0] r_dst;
    } stage_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

    function automatic logic signed [WRBITS-1:0] retime_weight(
        input logic [WBITS-1:0]        w,
        input logic signed [RBITS-1:0] rs,
        input logic signed [RBITS-1:0] rd
    );
        logic signed [WRBITS-1:0] ws, rse, rde;
        ws  = $signed({2'b00, w});
        rse = rs;
        rde = rd;
        return ws + rde - rse;
    endfunction
endpackage

// File: rtl/rtw_edge_store.sv
module rtw_edge_store
    import rtw_pkg::*;
(
    input  logic            clk,
    input  logic            we,
    input  logic [EIDX-1:0] waddr,
    input  edge_t           wdata,
    input  logic [EIDX-1:0] raddr,
    output edge_t           rdata
);
    edge_t mem [EDGES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rtw_node_store.sv
module rtw_node_store
    import rtw_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [NIDX-1:0]         waddr,
    input  logic signed [RBITS-1:0] wdata,
    input  logic [NIDX-1:0]         raddr_a,
    input  logic [NIDX-1:0]         raddr_b,
    output logic signed [RBITS-1:0] rdata_a,
    output logic signed [RBITS-1:0] rdata_b
);
    logic signed [RBITS-1:0] rv [NODES];

    for (genvar n = 0; n < NODES; n++) begin : g_node
        always_ff @(posedge clk) begin
            if (rst)                         rv[n] <= '0;
            else if (we && waddr == NIDX'(n)) rv[n] <= wdata;
        end
    end

    assign rdata_a = rv[raddr_a];
    assign rdata_b = rv[raddr_b];
endmodule

// File: rtl/rtw_result_store.sv
module rtw_result_store
    import rtw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [EIDX-1:0]          waddr,
    input  logic signed [WRBITS-1:0] wdata,
    input  logic [EIDX-1:0]          raddr,
    output logic signed [WRBITS-1:0] rdata
);
    logic signed [WRBITS-1:0] res [EDGES];

    for (genvar e = 0; e < EDGES; e++) begin : g_res
        always_ff @(posedge clk) begin
            if (rst)                          res[e] <= '0;
            else if (we && waddr == EIDX'(e)) res[e] <= wdata;
        end
    end

    assign rdata = res[raddr];
endmodule

// File: rtl/rtw_sequencer.sv
module rtw_sequencer
    import rtw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CNTB-1:0] num_edges,
    output logic            run_start,
    output logic            run_empty,
    output logic            issue_vld,
    output logic            issue_last,
    output logic [EIDX-1:0] issue_idx,
    output logic            busy
);
    seq_state_t      state;
    logic [CNTB-1:0] num_lat;
    logic [EIDX-1:0] idx;

    assign run_start  = (state == SEQ_IDLE) && start;
    assign run_empty  = run_start && (num_edges == '0);
    assign issue_vld  = (state == SEQ_ISSUE);
    assign issue_last = issue_vld && (CNTB'(idx) + CNTB'(1) == num_lat);
    assign issue_idx  = idx;
    assign busy       = (state != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            num_lat <= '0;
            idx     <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (run_start && !run_empty) begin
                        state   <= SEQ_ISSUE;
                        num_lat <= num_edges;
                        idx     <= '0;
                    end
                end
                SEQ_ISSUE: begin
                    if (issue_last) state <= SEQ_DRAIN;
                    else            idx   <= idx + EIDX'(1);
                end
                SEQ_DRAIN: state <= SEQ_IDLE;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    p_issue_bound_r10: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> (CNTB'(idx) < num_lat));

    p_issue_step_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !issue_last) |=> (issue_vld && idx == $past(idx) + EIDX'(1)));

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !issue_last) |=> $stable(num_lat));
endmodule

// File: rtl/rtw_eval.sv
module rtw_eval
    import rtw_pkg::*;
#(
    parameter bit ENABLE_TOTAL = 1'b1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_start,
    input  logic                     run_empty,
    input  logic                     issue_vld,
    input  logic                     issue_last,
    input  logic [EIDX-1:0]          issue_idx,
    input  edge_t                    issue_edge,
    input  logic signed [RBITS-1:0]  r_src,
    input  logic signed [RBITS-1:0]  r_dst,
    output logic                     res_we,
    output logic [EIDX-1:0]          res_addr,
    output logic signed [WRBITS-1:0] res_data,
    output logic                     done,
    output logic                     legal,
    output logic [EIDX-1:0]          viol_idx,
    output logic                     total_ok
);
    localparam int WMIN = -(1 <<< (RBITS)) + 1;
    localparam int WMAX = (1 <<< WBITS) - 1 + 2 * ((1 <<< (RBITS - 1)) - 1) + 2;

    stage_t                   s1;
    logic signed [WRBITS-1:0] wr;

    always_ff @(posedge clk) begin
        if (rst) s1 <= '0;
        else begin
            s1.vld   <= issue_vld;
            s1.last  <= issue_last;
            s1.idx   <= issue_idx;
            s1.w     <= issue_edge.w;
            s1.r_src <= r_src;
            s1.r_dst <= r_dst;
        end
    end

    assign wr       = retime_weight(s1.w, s1.r_src, s1.r_dst);
    assign res_we   = s1.vld;
    assign res_addr = s1.idx;
    assign res_data = wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            legal    <= 1'b1;
            viol_idx <= '0;
        end else begin
            done <= (s1.vld && s1.last) || run_empty;
            if (run_start) begin
                legal    <= 1'b1;
                viol_idx <= '0;
            end else if (s1.vld && wr < 0 && legal) begin
                legal    <= 1'b0;
                viol_idx <= s1.idx;
            end
        end
    end

    if (ENABLE_TOTAL) begin : g_total
        logic signed [SUMB-1:0] sum_w, sum_wr;
        always_ff @(posedge clk) begin
            if (rst || run_start) begin
                sum_w  <= '0;
                sum_wr <= '0;
            end else if (s1.vld) begin
                sum_w  <= sum_w + $signed({{(SUMB-WBITS){1'b0}}, s1.w});
                sum_wr <= sum_wr + SUMB'(wr);
            end
        end
        assign total_ok = (sum_w == sum_wr);
    end else begin : g_no_total
        assign total_ok = 1'b1;
    end

    p_neg_clears_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && !run_start && wr < 0) |=> !legal);

    p_viol_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!legal && !run_start) |=> (!legal && $stable(viol_idx)));

    p_done_after_last_r4: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && s1.last) |=> done);

    p_weight_range_r1: assert property (@(posedge clk) disable iff (rst)
        s1.vld |-> (int'(wr) >= WMIN && int'(wr) <= WMAX));
endmodule

// File: rtl/rtw_checker.sv
module rtw_checker
    import rtw_pkg::*;
#(
    parameter bit ENABLE_TOTAL = 1'b1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     edge_we,
    input  logic [EIDX-1:0]          edge_waddr,
    input  logic [NIDX-1:0]          edge_src,
    input  logic [NIDX-1:0]          edge_dst,
    input  logic [WBITS-1:0]         edge_w,
    input  logic                     node_we,
    input  logic [NIDX-1:0]          node_waddr,
    input  logic signed [RBITS-1:0]  node_r,
    input  logic [CNTB-1:0]          num_edges,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    input  logic [EIDX-1:0]          rd_idx,
    output logic signed [WRBITS-1:0] rd_weight,
    output logic                     legal,
    output logic [EIDX-1:0]          viol_idx,
    output logic                     total_ok
);
    edge_t                    wr_edge, cur_edge;
    logic                     run_start, run_empty, issue_vld, issue_last;
    logic [EIDX-1:0]          issue_idx, res_addr;
    logic signed [RBITS-1:0]  r_src, r_dst;
    logic                     res_we;
    logic signed [WRBITS-1:0] res_data;

    assign wr_edge = '{src: edge_src, dst: edge_dst, w: edge_w};

    rtw_edge_store u_edges (
        .clk(clk), .we(edge_we), .waddr(edge_waddr), .wdata(wr_edge),
        .raddr(issue_idx), .rdata(cur_edge)
    );

    rtw_node_store u_nodes (
        .clk(clk), .rst(rst), .we(node_we), .waddr(node_waddr), .wdata(node_r),
        .raddr_a(cur_edge.src), .raddr_b(cur_edge.dst),
        .rdata_a(r_src), .rdata_b(r_dst)
    );

    rtw_sequencer u_seq (
        .clk(clk), .rst(rst), .start(start), .num_edges(num_edges),
        .run_start(run_start), .run_empty(run_empty), .issue_vld(issue_vld),
        .issue_last(issue_last), .issue_idx(issue_idx), .busy(busy)
    );

    rtw_eval #(.ENABLE_TOTAL(ENABLE_TOTAL)) u_eval (
        .clk(clk), .rst(rst), .run_start(run_start), .run_empty(run_empty),
        .issue_vld(issue_vld), .issue_last(issue_last), .issue_idx(issue_idx),
        .issue_edge(cur_edge), .r_src(r_src), .r_dst(r_dst),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
        .done(done), .legal(legal), .viol_idx(viol_idx), .total_ok(total_ok)
    );

    rtw_result_store u_results (
        .clk(clk), .rst(rst), .we(res_we), .waddr(res_addr), .wdata(res_data),
        .raddr(rd_idx), .rdata(rd_weight)
    );
endmodule

// File: tb/tb_rtw_checker.sv
module tb_rtw_checker;
    logic              clk = 1'b0;
    logic              rst;
    logic              edge_we = 0;
    logic [4:0]        edge_waddr = 0;
    logic [3:0]        edge_src = 0, edge_dst = 0;
    logic [5:0]        edge_w = 0;
    logic              node_we = 0;
    logic [3:0]        node_waddr = 0;
    logic signed [5:0] node_r = 0;
    logic [5:0]        num_edges = 0;
    logic              start = 0;
    logic              busy, done, legal, total_ok;
    logic [4:0]        rd_idx = 0, viol_idx;
    logic signed [7:0] rd_weight;

    int n_tests = 0, n_fail = 0;
    int m_src[32], m_dst[32], m_w[32], m_r[16], saved[32];

    rtw_checker dut (.*);

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_w(int i);
        return m_w[i] + m_r[m_dst[i]] - m_r[m_src[i]];
    endfunction

    task automatic put_edge(int i, int s, int d, int w);
        @(negedge clk);
        edge_we = 1; edge_waddr = 5'(i); edge_src = 4'(s); edge_dst = 4'(d); edge_w = 6'(w);
        m_src[i] = s; m_dst[i] = d; m_w[i] = w;
        @(negedge clk);
        edge_we = 0;
    endtask

    task automatic put_r(int n, int r);
        @(negedge clk);
        node_we = 1; node_waddr = 4'(n); node_r = 6'(r); m_r[n] = r;
        @(negedge clk);
        node_we = 0;
    endtask

    task automatic run(int n, bit inject, string tag, output int lat);
        @(negedge clk);
        num_edges = 6'(n); start = 1;
        @(negedge clk);
        start = 0; lat = 1;
        while (!done && lat < 100) begin
            if (inject && lat == 3) begin start = 1; num_edges = 6'(1); end
            else start = 0;
            @(negedge clk);
            lat++;
        end
        start = 0;
        chk({tag, " R4 done latency"}, lat, (n == 0) ? 1 : n + 2);
        @(negedge clk);
        chk({tag, " R4 done one cycle"}, int'(done), 0);
        chk({tag, " R4 busy low after"}, int'(busy), 0);
    endtask

    task automatic verify(int n, string tag);
        int first = -1, sw = 0, swr = 0;
        for (int i = 0; i < n; i++) begin
            rd_idx = 5'(i);
            #1;
            chk({tag, " R1 weight"}, int'(rd_weight), exp_w(i));
            if (exp_w(i) < 0 && first < 0) first = i;
            sw += m_w[i]; swr += exp_w(i);
        end
        chk({tag, " R2 legal"}, int'(legal), first < 0);
        if (first >= 0) chk({tag, " R3 viol_idx"}, int'(viol_idx), first);
        chk({tag, " R8 total_ok"}, int'(total_ok), sw == swr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) m_r[i] = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", int'(busy), 0);
        chk("R9 done", int'(done), 0);
        chk("R9 legal", int'(legal), 1);
        chk("R9 viol_idx", int'(viol_idx), 0);
        chk("R9 total_ok", int'(total_ok), 1);

        // R1 extremes: +126, -63, self-loop
        put_r(1, 31); put_r(2, -32); put_r(3, 5);
        put_edge(0, 2, 1, 63);
        put_edge(1, 3, 3, 17);
        put_edge(2, 1, 2, 0);
        run(3, 0, "extremes", lat);
        verify(3, "extremes");
        chk("R3 viol at 2", int'(viol_idx), 2);

        // R5 empty pass
        run(0, 0, "empty", lat);
        chk("R5 legal", int'(legal), 1);

        // R8 ring graph over nodes 0..7
        for (int i = 0; i < 8; i++) put_r(i, int'($urandom_range(0, 30)) - 15);
        for (int i = 0; i < 8; i++) put_edge(i, i, (i + 1) % 8, int'($urandom_range(0, 40)));
        run(8, 0, "ring", lat);
        verify(8, "ring");
        chk("R8 ring total", int'(total_ok), 1);

        // R3 violations at index 0 and later
        for (int i = 0; i < 6; i++) put_edge(i, 4, 5, 3);
        put_r(4, 6); put_r(5, 0);
        run(6, 0, "allneg", lat);
        verify(6, "allneg");
        chk("R3 viol at 0", int'(viol_idx), 0);

        // R10 negative edge just beyond the active count
        put_r(4, 0);
        put_edge(6, 5, 4, 0); put_r(5, 9);
        for (int i = 0; i < 6; i++) put_edge(i, 4, 4, 1);
        run(6, 0, "bound", lat);
        verify(6, "bound");
        chk("R10 tail ignored legal", int'(legal), 1);

        // random graphs
        for (int t = 0; t < 12; t++) begin
            int n = int'($urandom_range(1, 32));
            for (int k = 0; k < 16; k++) put_r(k, int'($urandom_range(0, 16)) - 8);
            for (int i = 0; i < n; i++)
                put_edge(i, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                         int'($urandom_range(0, 15)));
            run(n, 0, "random", lat);
            verify(n, "random");
        end

        // R7 constant offset on all r
        for (int k = 0; k < 16; k++) put_r(k, int'($urandom_range(0, 24)) - 16);
        for (int i = 0; i < 32; i++)
            put_edge(i, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                     int'($urandom_range(0, 20)));
        run(32, 0, "pre-shift", lat);
        verify(32, "pre-shift");
        for (int i = 0; i < 32; i++) saved[i] = exp_w(i);
        for (int k = 0; k < 16; k++) put_r(k, m_r[k] + 7);
        run(32, 0, "shifted", lat);
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i);
            #1;
            chk("R7 shift invariance", int'(rd_weight), saved[i]);
        end

        // R6 restart attempt mid-pass
        run(20, 1, "R6 restart", lat);
        verify(20, "R6 restart");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule